// File: doc/BRIEF.md
# Two-Phase Noise Shift Register with Test Hold

This block is the noise source of a sound-generator oscillator. A 23-bit linear feedback register advances once for every rising edge of bit 19 of the phase accumulator. That edge reaches the block as a one-cycle pulse. The advance is split across two clock edges. The first edge captures the register into a latch. The second edge writes the latch back shifted up by one place, with a fresh feedback bit at the bottom. Eight register bits are spread across the upper part of a 12-bit output word, which is ready to be mixed with the other waveforms.

A test input stops the register in the capture phase. While test is high the latch follows the register, and pending shifts are dropped. When test is released, one shift completes, and its feedback is forced high before the XOR. If test stays high for a long time, a timer slowly floods the register with ones. When the timer expires, every set bit also sets the bit above it. The timer then restarts with a shorter reload until the register is all ones. A parameter selects the timing of the older or the newer silicon model.

Top module: `noise_lfsr_2ph`

## Requirements
- R1: After reset the register holds 0x7FFFFE (all ones with bit 0 clear), the latch holds all ones, and the output word is 0xFE0.
- R2: A pulse on `acc_rise_i` sampled at edge k, with test low, copies the register into the latch at edge k+1. At edge k+2 the register becomes {latch[21:0], latch[22] XOR latch[17]}.
- R3: Output bits 11 down to 4 carry register bits 20, 18, 14, 11, 9, 5, 2 and 0 in that order. Output bits 3..0 and any bits above 11 are zero.
- R4: At the edge where test is first sampled high, the latch captures the register and any pending shift phase is discarded. While test stays high the register changes only by the fill of R7, and the latch follows the register's new value.
- R5: At the first edge where test is sampled low again, the register becomes {latch[21:0], NOT latch[17]}. The feedback is forced, so latch[22] plays no part.
- R6: A pulse on `acc_rise_i` sampled while test is high starts no shift.
- R7: The edge where test rises loads the timer with the hold count. Each later edge with test high decrements it. An edge with test high and the timer at zero replaces the register with (reg OR reg<<1) with bit 0 set.
- R8: After a fill that does not yet leave all ones, the timer reloads with the fade count, so the next fill comes fade+1 edges later. Once the register is all ones it stays all ones while test is held.
- R9: `NEWER_MODEL`=0 selects hold/fade counts of 50000/15000 by default. `NEWER_MODEL`=1 selects 986000/314300. Both pairs are overridable parameters.
- R10: Two events on the same edge both take effect. At a release edge the forced commit happens and a new pulse starts a shift. A pending commit at the edge where test rises is cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_rise_i | input | 1 | One-cycle pulse: accumulator bit 19 rose |
| test_i | input | 1 | Test line; holds the shift in its capture phase |
| noise_o | output | OUT_W | Noise word, bits 11..4 from the register |

## Verification
Two pairs of events can land on the same edge, and the bench provokes both. First, the release of test can coincide with a fresh accumulator pulse. The bench drives the pulse in the cycle where test drops. It then expects the forced commit at that edge, followed two edges later by a normal shift taken from the committed value. Second, test can rise while a commit is pending. The bench raises test one cycle after the latch phase and expects the register to hold its value. A reference model, built from the requirements, runs beside two instances (one per model setting) with reduced counts. It predicts every output word, and the scoreboard compares each one, so the slow fill and its reload spacing are checked on every cycle as well.

// File: rtl/noise_lfsr_pkg.sv
package noise_lfsr_pkg;
   localparam int unsigned SR_W   = 23;
   localparam int unsigned TAP_HI = 22;
   localparam int unsigned TAP_LO = 17;

   typedef logic [SR_W-1:0] sr_t;

   function automatic logic [7:0] sr_to_noise(input sr_t r);
      return {r[20], r[18], r[14], r[11], r[9], r[5], r[2], r[0]};
   endfunction

   function automatic sr_t sr_fold_up(input sr_t r);
      return r | {r[SR_W-2:0], 1'b1};
   endfunction

   function automatic sr_t sr_step(input sr_t l, input logic force_fb);
      return {l[SR_W-2:0], (l[TAP_HI] | force_fb) ^ l[TAP_LO]};
   endfunction
endpackage

// File: rtl/noise_phase_ctrl.sv
module noise_phase_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic acc_rise_i,
   input  logic test_i,
   output logic rise_edge_o,
   output logic hold_o,
   output logic release_o,
   output logic do_latch_o,
   output logic do_commit_o
);
   logic s1_q, s2_q, tq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_q <= 1'b0;
         s2_q <= 1'b0;
         tq_q <= 1'b0;
      end else begin
         tq_q <= test_i;
         if (test_i) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
         end else begin
            s1_q <= acc_rise_i;
            s2_q <= s1_q;
         end
      end
   end

   always_comb begin
      rise_edge_o = test_i & ~tq_q;
      hold_o      = test_i & tq_q;
      release_o   = ~test_i & tq_q;
      do_latch_o  = ~test_i & s1_q;
      do_commit_o = ~test_i & ~tq_q & s2_q;
   end

   a_r6_pulse_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      test_i |=> !s1_q);
   a_r4_pipeline_flush: assert property (@(posedge clk) disable iff (!rst_n)
      test_i |=> !s2_q);
   a_r2_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
      s2_q |-> $past(s1_q));
endmodule

// File: rtl/noise_fade_timer.sv
module noise_fade_timer #(
   parameter int unsigned HOLD_CNT = 50000,
   parameter int unsigned FADE_CNT = 15000,
   localparam int unsigned CNT_W = $clog2((HOLD_CNT > FADE_CNT ? HOLD_CNT : FADE_CNT) + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rise_edge_i,
   input  logic hold_i,
   input  logic fill_full_i,
   output logic fire_o
);
   logic [CNT_W-1:0] cnt_q;

   initial begin
      assert (HOLD_CNT > 0) else $error("HOLD_CNT must be nonzero");
      assert (FADE_CNT > 0) else $error("FADE_CNT must be nonzero");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (rise_edge_i) begin
         cnt_q <= CNT_W'(HOLD_CNT);
      end else if (hold_i) begin
         if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
         else if (!fill_full_i)
            cnt_q <= CNT_W'(FADE_CNT);
      end
   end

   assign fire_o = hold_i && (cnt_q == '0);

   a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q <= CNT_W'(HOLD_CNT)) || (cnt_q <= CNT_W'(FADE_CNT)));
   a_r8_fade_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_o && !fill_full_i && !rise_edge_i) |=> cnt_q == CNT_W'(FADE_CNT));
   a_r7_hold_load: assert property (@(posedge clk) disable iff (!rst_n)
      rise_edge_i |=> cnt_q == CNT_W'(HOLD_CNT));
endmodule

// File: rtl/noise_sr_core.sv
module noise_sr_core
   import noise_lfsr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic rise_edge_i,
   input  logic hold_i,
   input  logic release_i,
   input  logic do_latch_i,
   input  logic do_commit_i,
   input  logic fire_i,
   output logic fill_full_o,
   output sr_t  reg_o
);
   sr_t reg_q, lat_q, reg_d, lat_d, folded;

   assign folded      = sr_fold_up(reg_q);
   assign fill_full_o = &folded;

   always_comb begin
      reg_d = reg_q;
      if (hold_i && fire_i)
         reg_d = folded;
      else if (release_i)
         reg_d = sr_step(lat_q, 1'b1);
      else if (do_commit_i)
         reg_d = sr_step(lat_q, 1'b0);
   end

   always_comb begin
      lat_d = lat_q;
      if (rise_edge_i || do_latch_i)
         lat_d = reg_q;
      else if (hold_i)
         lat_d = reg_d;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_q <= {{(SR_W-1){1'b1}}, 1'b0};
         lat_q <= '1;
      end else begin
         reg_q <= reg_d;
         lat_q <= lat_d;
      end
   end

   assign reg_o = reg_q;

   a_r7_fill_keeps_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_i && fire_i) |=> ((reg_q & $past(reg_q)) == $past(reg_q)) && reg_q[0]);
   a_r5_release_fb: assert property (@(posedge clk) disable iff (!rst_n)
      release_i |=> reg_q[0] == ~$past(lat_q[TAP_LO]));
   a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_i && !fire_i) |=> $stable(reg_q));
   a_r8_full_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_i && (&reg_q)) |=> (&reg_q));
endmodule

// File: rtl/noise_lfsr_2ph.sv
module noise_lfsr_2ph
   import noise_lfsr_pkg::*;
#(
   parameter bit          NEWER_MODEL = 1'b0,
   parameter int unsigned HOLD_OLD    = 50000,
   parameter int unsigned FADE_OLD    = 15000,
   parameter int unsigned HOLD_NEW    = 986000,
   parameter int unsigned FADE_NEW    = 314300,
   parameter int unsigned OUT_W       = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_rise_i,
   input  logic             test_i,
   output logic [OUT_W-1:0] noise_o
);
   localparam int unsigned NOISE_LSB = 4;

   initial begin
      assert (OUT_W >= 12) else $error("OUT_W must hold bits 11..4");
   end

   logic rise_edge, hold, rel, do_latch, do_commit, fire, fill_full;
   sr_t  sr;

   noise_phase_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc_rise_i  (acc_rise_i),
      .test_i      (test_i),
      .rise_edge_o (rise_edge),
      .hold_o      (hold),
      .release_o   (rel),
      .do_latch_o  (do_latch),
      .do_commit_o (do_commit)
   );

   generate
      if (NEWER_MODEL) begin : g_new
         noise_fade_timer #(.HOLD_CNT(HOLD_NEW), .FADE_CNT(FADE_NEW)) u_timer (
            .clk(clk), .rst_n(rst_n), .rise_edge_i(rise_edge), .hold_i(hold),
            .fill_full_i(fill_full), .fire_o(fire));
      end else begin : g_old
         noise_fade_timer #(.HOLD_CNT(HOLD_OLD), .FADE_CNT(FADE_OLD)) u_timer (
            .clk(clk), .rst_n(rst_n), .rise_edge_i(rise_edge), .hold_i(hold),
            .fill_full_i(fill_full), .fire_o(fire));
      end
   endgenerate

   noise_sr_core u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .rise_edge_i (rise_edge),
      .hold_i      (hold),
      .release_i   (rel),
      .do_latch_i  (do_latch),
      .do_commit_i (do_commit),
      .fire_i      (fire),
      .fill_full_o (fill_full),
      .reg_o       (sr)
   );

   always_comb begin
      noise_o = '0;
      noise_o[NOISE_LSB +: 8] = sr_to_noise(sr);
   end

   a_r1_reset_word: assert property (@(posedge clk)
      !rst_n |=> noise_o[11:0] == 12'hFE0);
endmodule

// File: tb/noise_lfsr_2ph_tb.sv
module noise_lfsr_2ph_tb;
   localparam int CLK_PERIOD = 10;
   localparam int H0 = 20, F0 = 6, H1 = 30, F1 = 9;

   logic clk = 1'b0, rst_n = 1'b0, rise = 1'b0, tst = 1'b0;
   logic [11:0] out0, out1;
   int checks = 0, errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   noise_lfsr_2ph #(.NEWER_MODEL(1'b0), .HOLD_OLD(H0), .FADE_OLD(F0),
      .HOLD_NEW(H1), .FADE_NEW(F1)) u_dut (
      .clk(clk), .rst_n(rst_n), .acc_rise_i(rise), .test_i(tst), .noise_o(out0));
   noise_lfsr_2ph #(.NEWER_MODEL(1'b1), .HOLD_OLD(H0), .FADE_OLD(F0),
      .HOLD_NEW(H1), .FADE_NEW(F1)) u_dut_new (
      .clk(clk), .rst_n(rst_n), .acc_rise_i(rise), .test_i(tst), .noise_o(out1));

   // reference model state, index 0 = older model, 1 = newer model
   logic [22:0] m_reg[2], m_lat[2];
   bit m_s1[2], m_s2[2], m_tq[2];
   int m_cnt[2];
   logic [11:0] exp_q0[$], exp_q1[$];
   string tag_q[$];
   bit mon_on = 1'b0;

   function automatic logic [11:0] to_word(logic [22:0] r);
      return {r[20], r[18], r[14], r[11], r[9], r[5], r[2], r[0], 4'b0000};
   endfunction

   task automatic check(string req, logic [11:0] act, logic [11:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_step(int i, bit r, bit t);
      logic [22:0] cr = m_reg[i], cl = m_lat[i], nr, nl;
      int hold = (i == 0) ? H0 : H1, fade = (i == 0) ? F0 : F1;
      nr = cr; nl = cl;
      if (t && !m_tq[i]) begin
         nl = cr; m_s1[i] = 0; m_s2[i] = 0; m_cnt[i] = hold;
      end else if (t) begin
         if (m_cnt[i] == 0) begin
            nr = cr | {cr[21:0], 1'b1};
            if (nr != 23'h7FFFFF) m_cnt[i] = fade;
         end else m_cnt[i]--;
         nl = nr; m_s1[i] = 0; m_s2[i] = 0;
      end else begin
         if (m_tq[i]) nr = {cl[21:0], ~cl[17]};
         else if (m_s2[i]) nr = {cl[21:0], cl[22] ^ cl[17]};
         if (m_s1[i]) nl = cr;
         m_s2[i] = m_s1[i]; m_s1[i] = r;
      end
      m_tq[i] = t; m_reg[i] = nr; m_lat[i] = nl;
   endtask

   // driver: sets inputs for the next edge, pushes the predicted words
   task automatic step(bit r, bit t, string req);
      @(negedge clk);
      rise = r; tst = t;
      model_step(0, r, t);
      model_step(1, r, t);
      exp_q0.push_back(to_word(m_reg[0]));
      exp_q1.push_back(to_word(m_reg[1]));
      tag_q.push_back(req);
   endtask

   // monitor: compares after each edge
   always @(posedge clk) begin
      #1;
      if (mon_on && exp_q0.size() > 0) begin
         string t = tag_q.pop_front();
         check(t, out0, exp_q0.pop_front());
         check({t, "/R9"}, out1, exp_q1.pop_front());
      end
   end

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 2; i++) begin
         m_reg[i] = 23'h7FFFFE; m_lat[i] = 23'h7FFFFF;
         m_s1[i] = 0; m_s2[i] = 0; m_tq[i] = 0; m_cnt[i] = 0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      check("R1 reset word", out0, 12'hFE0);
      check("R1 reset word new", out1, 12'hFE0);
      mon_on = 1'b1;
      // R2 R3: spaced shifts
      for (int n = 0; n < 80; n++) begin
         step(1, 0, "R2");
         step(0, 0, "R3");
         step(0, 0, "R2");
         step(0, 0, "R3");
      end
      // back-to-back pulses
      for (int n = 0; n < 6; n++) step(1, 0, "R2");
      step(0, 0, "R2"); step(0, 0, "R2");
      // R6: pulses during a short hold, then R5 release
      step(0, 1, "R4");
      step(1, 1, "R6");
      step(1, 1, "R6");
      step(0, 0, "R5");
      step(0, 0, "R5"); step(0, 0, "R5");
      // R10: test rises while commit is pending
      step(1, 0, "R10");
      step(0, 0, "R10");
      step(0, 1, "R10");
      step(0, 1, "R4");
      // R10: release together with a new pulse
      step(1, 0, "R10");
      step(0, 0, "R10"); step(0, 0, "R10"); step(0, 0, "R10");
      // R7 R8: long hold until the fill completes
      for (int n = 0; n < 260; n++) step(0, 1, (n < 40) ? "R7" : "R8");
      @(negedge clk);
      check("R8 full after long hold", out0, 12'hFF0);
      check("R8 full after long hold new", out1, 12'hFF0);
      step(0, 0, "R5");
      for (int n = 0; n < 30; n++) begin
         step(1, 0, "R2"); step(0, 0, "R2"); step(0, 0, "R2");
      end
      // R9: hold only past the older timer, newer model must not fill yet
      for (int n = 0; n < 25; n++) step(0, 1, "R9");
      step(0, 0, "R9");
      repeat (3) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule